// File: doc/BRIEF.md
# Direct-Mapped Split-Tag Translation Cache

This block caches recent virtual-to-physical page mappings so that most accesses skip the slow translation path. It is direct mapped. Every slot holds one translation offset, the physical address minus the virtual address, and that offset is shared by three tag arrays: one for instruction fetch, one for loads and one for stores. A lookup gives a virtual address and an access type. One cycle later the block returns hit or miss and, on a hit, the physical address, which is the virtual address plus the stored offset.

The slow path refills a slot after it has translated an address that maps to ordinary memory. The refill writes the tag of its own access type, updates the shared offset, and invalidates any other tag at that slot that names a different page. If a watch on the refilling access type is armed, the written tag carries a mark bit. Later lookups of that type then miss and go back to the slow path. A flush empties every slot.

Top module: `split_tag_tlb`

## Requirements
- R1: The slot index is the low log2(ENTRIES) bits of the virtual page number (vaddr >> PAGE_SHIFT). Two pages with the same index displace each other within one access type, and pages with other indices are not affected.
- R2: A lookup (lk_valid=1) with type code 0=fetch, 1=load or 2=store hits in the cycle after it is presented. It hits when the tag of that type at the slot holds the full page number without a mark. lk_paddr is then lk_vaddr plus (refill paddr − refill vaddr) of the last refill of that slot.
- R3: The three access types keep separate tags. A refill of one type alone does not make lookups of the other two types hit.
- R4: A refill invalidates the tags of the other two types at its slot when those tags name a different page number, with the mark ignored. It keeps them when they name the same page number, and the shared offset is updated in both cases.
- R5: If trig_en bit k is 1 (bit k belongs to type code k) during a refill of type k, the written tag is marked and later lookups of type k for that page miss. For the keep-or-invalidate decision of a later refill of another type, the mark is ignored.
- R6: When flush=1, every tag of all three types becomes invalid at the next edge, and a lookup in the same cycle as the flush reports a miss.
- R7: A refill with rf_cacheable=0, or with type code 3, changes no tag and no offset.
- R8: A lookup and a refill to the same slot in the same cycle report a miss, and the refill is applied. A lookup to a different slot in that cycle uses the state before the refill.
- R9: A lookup with type code 3 always misses.
- R10: After reset, all slots are invalid. Whenever the block reports a miss, lk_paddr is 0, and lk_hit is 0 when no lookup was presented.
- R11: The all-ones page number misses while its slot is invalid and hits once it has been refilled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all slots |
| trig_en | input | 3 | Per-type watch enable, bit k for type code k |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | ADDR_W | Lookup virtual address |
| lk_type | input | 2 | Lookup access type code |
| rf_valid | input | 1 | Refill request |
| rf_vaddr | input | ADDR_W | Refill virtual address |
| rf_paddr | input | ADDR_W | Refill physical address |
| rf_type | input | 2 | Refill access type code |
| rf_cacheable | input | 1 | Refill target is ordinary memory |
| lk_hit | output | 1 | Registered lookup hit |
| lk_paddr | output | ADDR_W | Registered physical address, 0 on a miss |

## Verification
A lookup result appears one edge after the lookup is presented. A refill or flush changes the arrays at its edge, so the earliest lookup that can see the change is presented in the next cycle, and its result lands one edge after that. The bench drives every input on the falling edge. It computes the expected result from a page-level model of the requirements using the state before that cycle's update, and it compares lk_hit and lk_paddr at the following falling edge. Because of this, same-cycle refill and flush collisions are judged against the old state, as R8 and R6 require.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   localparam int NUM_KINDS = 3;
   localparam logic [1:0] KIND_FETCH = 2'd0;
   localparam logic [1:0] KIND_LOAD  = 2'd1;
   localparam logic [1:0] KIND_STORE = 2'd2;
   localparam logic [1:0] KIND_NONE  = 2'd3;
endpackage

// File: rtl/tlb_tag_array.sv
module tlb_tag_array #(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 52,
   parameter int IDX_W   = $clog2(ENTRIES),
   parameter int KIND    = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [VPN_W-1:0] wr_vpn,
   input  logic [1:0]       wr_kind,
   input  logic             wr_mark,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic [VPN_W-1:0] rd_vpn,
   output logic             rd_match
);
   localparam int TAG_W = VPN_W + 1;

   logic [TAG_W-1:0] tags [ENTRIES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) tags[i] <= '1;
      end else if (flush) begin
         for (int i = 0; i < ENTRIES; i++) tags[i] <= '1;
      end else if (wr_en) begin
         if (wr_kind == 2'(KIND))
            tags[wr_idx] <= {wr_mark, wr_vpn};
         else if (tags[wr_idx][VPN_W-1:0] != wr_vpn)
            tags[wr_idx] <= '1;
      end
   end

   // unmarked tag only: the top bit must be clear
   assign rd_match = (tags[rd_idx] == {1'b0, rd_vpn});

   // R6
   flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !rd_match);
endmodule

// File: rtl/tlb_data_array.sv
module tlb_data_array #(
   parameter int ENTRIES = 16,
   parameter int ADDR_W  = 64,
   parameter int IDX_W   = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_vaddr,
   input  logic [ADDR_W-1:0] wr_paddr,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [ADDR_W-1:0] rd_vaddr,
   output logic [ADDR_W-1:0] rd_paddr
);
   logic [ADDR_W-1:0] offs [ENTRIES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) offs[i] <= '0;
      end else if (wr_en) begin
         offs[wr_idx] <= wr_paddr - wr_vaddr;
      end
   end

   assign rd_paddr = rd_vaddr + offs[rd_idx];
endmodule

// File: rtl/tlb_result_reg.sv
module tlb_result_reg #(
   parameter int ADDR_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              tag_ok,
   input  logic              blocked,
   input  logic [ADDR_W-1:0] paddr_d,
   output logic              hit_q,
   output logic [ADDR_W-1:0] paddr_q
);
   logic hit_d;
   assign hit_d = req & tag_ok & ~blocked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_q   <= 1'b0;
         paddr_q <= '0;
      end else begin
         hit_q   <= hit_d;
         paddr_q <= hit_d ? paddr_d : '0;
      end
   end
endmodule

// File: rtl/split_tag_tlb.sv
module split_tag_tlb
   import tlb_pkg::*;
#(
   parameter int ENTRIES    = 16,
   parameter int PAGE_SHIFT = 12,
   parameter int ADDR_W     = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [2:0]        trig_en,
   input  logic              lk_valid,
   input  logic [ADDR_W-1:0] lk_vaddr,
   input  logic [1:0]        lk_type,
   input  logic              rf_valid,
   input  logic [ADDR_W-1:0] rf_vaddr,
   input  logic [ADDR_W-1:0] rf_paddr,
   input  logic [1:0]        rf_type,
   input  logic              rf_cacheable,
   output logic              lk_hit,
   output logic [ADDR_W-1:0] lk_paddr
);
   localparam int IDX_W = $clog2(ENTRIES);
   localparam int VPN_W = ADDR_W - PAGE_SHIFT;

   initial begin
      entries_pow2_chk: assert (ENTRIES >= 2 && (ENTRIES & (ENTRIES - 1)) == 0)
         else $error("ENTRIES must be a power of two, at least 2");
      vpn_width_chk: assert (PAGE_SHIFT > 0 && VPN_W > IDX_W)
         else $error("address too narrow for page shift and index");
   end

   logic [VPN_W-1:0] lk_vpn, rf_vpn;
   logic [IDX_W-1:0] lk_idx, rf_idx;
   logic             rf_fire, clash;
   logic [3:0]       match_vec;
   logic [3:0]       mark_vec;
   logic [ADDR_W-1:0] paddr_d;

   assign lk_vpn  = lk_vaddr[ADDR_W-1:PAGE_SHIFT];
   assign rf_vpn  = rf_vaddr[ADDR_W-1:PAGE_SHIFT];
   assign lk_idx  = lk_vpn[IDX_W-1:0];
   assign rf_idx  = rf_vpn[IDX_W-1:0];
   assign rf_fire = rf_valid & rf_cacheable & (rf_type != KIND_NONE);
   assign clash   = rf_fire & (rf_idx == lk_idx);
   assign mark_vec = {1'b0, trig_en};

   assign match_vec[3] = 1'b0;
   for (genvar k = 0; k < NUM_KINDS; k++) begin : g_tag
      tlb_tag_array #(
         .ENTRIES(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W), .KIND(k)
      ) u_tag (
         .clk(clk), .rst_n(rst_n), .flush(flush),
         .wr_en(rf_fire), .wr_idx(rf_idx), .wr_vpn(rf_vpn),
         .wr_kind(rf_type), .wr_mark(trig_en[k]),
         .rd_idx(lk_idx), .rd_vpn(lk_vpn), .rd_match(match_vec[k])
      );
   end

   tlb_data_array #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_data (
      .clk(clk), .rst_n(rst_n),
      .wr_en(rf_fire & ~flush), .wr_idx(rf_idx),
      .wr_vaddr(rf_vaddr), .wr_paddr(rf_paddr),
      .rd_idx(lk_idx), .rd_vaddr(lk_vaddr), .rd_paddr(paddr_d)
   );

   tlb_result_reg #(.ADDR_W(ADDR_W)) u_res (
      .clk(clk), .rst_n(rst_n),
      .req(lk_valid), .tag_ok(match_vec[lk_type]),
      .blocked(clash | flush), .paddr_d(paddr_d),
      .hit_q(lk_hit), .paddr_q(lk_paddr)
   );

   logic [1:0] chk_age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             chk_age <= '0;
      else if (chk_age != 2'd2) chk_age <= chk_age + 2'd1;
   end

   // R8
   clash_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && rf_valid && rf_cacheable && rf_type != KIND_NONE
       && rf_vaddr[PAGE_SHIFT+IDX_W-1:PAGE_SHIFT] == lk_vaddr[PAGE_SHIFT+IDX_W-1:PAGE_SHIFT])
      |=> !lk_hit);

   // R9
   bad_type_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_type == KIND_NONE) |=> !lk_hit);

   // R2
   refill_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_age == 2'd2 && lk_valid && !rf_valid && !flush
       && $past(rf_fire && !flush && !mark_vec[rf_type])
       && lk_type == $past(rf_type) && lk_vpn == $past(rf_vpn))
      |=> (lk_hit && lk_paddr == $past(lk_vaddr) + $past(rf_paddr, 2) - $past(rf_vaddr, 2)));

   // R5
   trig_mark_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_age != 2'd0 && lk_valid && !rf_valid && !flush
       && $past(rf_fire && !flush && mark_vec[rf_type])
       && lk_type == $past(rf_type) && lk_vpn == $past(rf_vpn))
      |=> !lk_hit);

   // R6
   flush_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !lk_hit);
endmodule

// File: tb/split_tag_tlb_test.sv
`timescale 1ns/1ps
module split_tag_tlb_test;
   localparam int ENTRIES = 16;
   localparam int PS = 12;
   localparam int AW = 64;
   localparam int VW = AW - PS;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush = 1'b0;
   logic [2:0] trig_en = 3'b000;
   logic lk_valid = 1'b0;
   logic [AW-1:0] lk_vaddr = '0;
   logic [1:0] lk_type = 2'd0;
   logic rf_valid = 1'b0;
   logic [AW-1:0] rf_vaddr = '0;
   logic [AW-1:0] rf_paddr = '0;
   logic [1:0] rf_type = 2'd0;
   logic rf_cacheable = 1'b0;
   logic lk_hit;
   logic [AW-1:0] lk_paddr;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   logic [VW:0]   m_tag [3][ENTRIES];
   logic [AW-1:0] m_off [ENTRIES];

   always #5 clk = ~clk;

   split_tag_tlb #(.ENTRIES(ENTRIES), .PAGE_SHIFT(PS), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .trig_en(trig_en),
      .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_type(lk_type),
      .rf_valid(rf_valid), .rf_vaddr(rf_vaddr), .rf_paddr(rf_paddr),
      .rf_type(rf_type), .rf_cacheable(rf_cacheable),
      .lk_hit(lk_hit), .lk_paddr(lk_paddr)
   );

   function automatic logic [AW-1:0] va(input logic [VW-1:0] vpn, input logic [PS-1:0] off);
      return {vpn, off};
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   // one cycle: drive at falling edge, check result at next falling edge
   task automatic cyc(input logic lv, input logic [AW-1:0] lva, input logic [1:0] lt,
                      input logic rv, input logic [AW-1:0] rva, input logic [AW-1:0] rpa,
                      input logic [1:0] rt, input logic rc, input logic fl,
                      input int want, input string tag);
      logic [VW-1:0] lvpn, rvpn;
      int li, ri;
      logic rfire, mh, eh;
      logic [AW-1:0] ep;
      lk_valid = lv; lk_vaddr = lva; lk_type = lt;
      rf_valid = rv; rf_vaddr = rva; rf_paddr = rpa; rf_type = rt;
      rf_cacheable = rc; flush = fl;
      lvpn = lva[AW-1:PS]; rvpn = rva[AW-1:PS];
      li = int'(lvpn[3:0]); ri = int'(rvpn[3:0]);
      rfire = rv && rc && (rt != 2'd3);
      mh = 1'b0;
      if (lv && lt != 2'd3 && !fl && !(rfire && ri == li))
         mh = (m_tag[lt][li] == {1'b0, lvpn});
      eh = (want < 0) ? mh : (want != 0);
      ep = eh ? lva + m_off[li] : '0;
      if (fl) begin
         for (int t = 0; t < 3; t++)
            for (int i = 0; i < ENTRIES; i++) m_tag[t][i] = '1;
      end else if (rfire) begin
         for (int t = 0; t < 3; t++) begin
            if (t == int'(rt)) m_tag[t][ri] = {trig_en[t], rvpn};
            else if (m_tag[t][ri][VW-1:0] != rvpn) m_tag[t][ri] = '1;
         end
         m_off[ri] = rpa - rva;
      end
      @(negedge clk);
      checks++;
      if (lk_hit !== eh || lk_paddr !== ep) begin
         failures++;
         $display("FAIL %s: hit=%0b paddr=%h expected hit=%0b paddr=%h",
                  tag, lk_hit, lk_paddr, eh, ep);
      end
   endtask

   task automatic look(input logic [AW-1:0] a, input logic [1:0] t, input int want, input string tag);
      cyc(1, a, t, 0, '0, '0, 2'd0, 0, 0, want, tag);
   endtask

   task automatic fill(input logic [AW-1:0] a, input logic [AW-1:0] p, input logic [1:0] t,
                       input logic c, input string tag);
      cyc(0, '0, 2'd0, 1, a, p, t, c, 0, 0, tag);
   endtask

   initial begin
      #2_000_000;
      failures++;
      $display("FAIL watchdog: run hung, expected completion");
      finish_run();
   end

   initial begin
      logic [VW-1:0] A, B, C, X, X2, M, N, ONES;
      A = 52'h105; B = 52'h205; C = 52'h307; X = 52'h10A; X2 = 52'h11A;
      M = 52'h409; N = 52'h50C; ONES = '1;
      for (int t = 0; t < 3; t++)
         for (int i = 0; i < ENTRIES; i++) m_tag[t][i] = '1;
      for (int i = 0; i < ENTRIES; i++) m_off[i] = '0;
      void'($urandom(32'd4711));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (lk_hit !== 1'b0 || lk_paddr !== '0) begin
         failures++;
         $display("FAIL R10 reset: hit=%0b paddr=%h expected hit=0 paddr=0", lk_hit, lk_paddr);
      end
      look(va(ONES, 12'h010), 2'd1, 0, "R11 all-ones page invalid");
      look(va(A, 12'h000), 2'd0, 0, "R10 empty slot");

      fill(va(A, 12'h123), 64'h0000_0087_6543_2123, 2'd1, 1, "R2 refill load");
      look(va(A, 12'h456), 2'd1, 1, "R2 load hit");
      look(va(A, 12'h456), 2'd0, 0, "R3 fetch separate");
      look(va(A, 12'h456), 2'd2, 0, "R3 store separate");

      fill(va(A, 12'h000), 64'h0000_00AA_0000_0000, 2'd0, 1, "R4 refill fetch same page");
      look(va(A, 12'h0FF), 2'd1, 1, "R4 load kept");
      look(va(A, 12'h0FF), 2'd0, 1, "R4 fetch hit");
      fill(va(B, 12'h000), 64'h0000_00BB_0000_0000, 2'd2, 1, "R4 refill store other page");
      look(va(A, 12'h001), 2'd1, 0, "R4 load invalidated");
      look(va(A, 12'h001), 2'd0, 0, "R4 fetch invalidated");
      look(va(B, 12'h001), 2'd2, 1, "R4 store hit");

      fill(va(X, 12'h000), 64'h0000_0001_0000_0000, 2'd1, 1, "R1 refill X");
      look(va(X, 12'h777), 2'd1, 1, "R1 X hit");
      fill(va(X2, 12'h000), 64'h0000_0002_0000_0000, 2'd1, 1, "R1 refill alias");
      look(va(X, 12'h777), 2'd1, 0, "R1 X displaced");
      look(va(X2, 12'h777), 2'd1, 1, "R1 alias hit");
      look(va(B, 12'h002), 2'd2, 1, "R1 other slot intact");

      cyc(1, va(C, 12'h010), 2'd1, 1, va(C, 12'h000), 64'h0000_0003_0000_0000, 2'd1, 1, 0, 0, "R8 same slot miss");
      look(va(C, 12'h010), 2'd1, 1, "R8 refill applied");
      cyc(1, va(X2, 12'h010), 2'd1, 1, va(C, 12'h000), 64'h0000_0004_0000_0000, 2'd1, 1, 0, 1, "R8 other slot hit");
      look(va(C, 12'h020), 2'd3, 0, "R9 type 3 miss");

      trig_en = 3'b010;
      fill(va(M, 12'h000), 64'h0000_0005_0000_0000, 2'd1, 1, "R5 marked refill");
      look(va(M, 12'h040), 2'd1, 0, "R5 marked miss");
      trig_en = 3'b000;
      fill(va(M, 12'h000), 64'h0000_0006_0000_0000, 2'd0, 1, "R5 fetch refill");
      look(va(M, 12'h040), 2'd0, 1, "R5 fetch hit");
      look(va(M, 12'h040), 2'd1, 0, "R5 load still marked");

      fill(va(N, 12'h000), 64'h0000_0007_0000_0000, 2'd1, 0, "R7 device refill");
      look(va(N, 12'h000), 2'd1, 0, "R7 no load hit");
      fill(va(N, 12'h000), 64'h0000_0007_0000_0000, 2'd3, 1, "R7 type 3 refill");
      look(va(N, 12'h000), 2'd0, 0, "R7 no fetch hit");
      look(va(N, 12'h000), 2'd2, 0, "R7 no store hit");
      fill(va(52'h605, 12'h000), 64'h0000_0008_0000_0000, 2'd1, 0, "R7 device refill slot 5");
      look(va(B, 12'h003), 2'd2, 1, "R7 store B untouched");

      fill(va(ONES, 12'h000), 64'h0000_0009_0000_0000, 2'd2, 1, "R11 refill all-ones");
      look(va(ONES, 12'h111), 2'd2, 1, "R11 all-ones hit");

      cyc(1, va(B, 12'h004), 2'd2, 0, '0, '0, 2'd0, 0, 1, 0, "R6 lookup during flush");
      look(va(B, 12'h004), 2'd2, 0, "R6 flushed store");
      look(va(C, 12'h004), 2'd1, 0, "R6 flushed load");
      look(va(ONES, 12'h004), 2'd2, 0, "R6 flushed all-ones");

      for (int n = 0; n < 3000; n++) begin
         logic [VW-1:0] lv_p, rv_p;
         logic [AW-1:0] rp;
         lv_p = VW'($urandom % 40);
         if ($urandom % 25 == 0) lv_p = '1;
         rv_p = VW'($urandom % 40);
         if ($urandom % 25 == 0) rv_p = '1;
         rp = {$urandom, $urandom};
         rp[PS-1:0] = 12'h000;
         if ($urandom % 10 == 0) trig_en = ($urandom % 3 == 0) ? 3'($urandom) : 3'b000;
         cyc(($urandom % 10) < 7, va(lv_p, 12'($urandom)), 2'($urandom % 4),
             ($urandom % 10) < 3, va(rv_p, 12'h000), rp, 2'($urandom % 4),
             ($urandom % 10) != 0, ($urandom % 60) == 0, -1, "R2 random mix");
      end
      finish_run();
   end
endmodule